// File: doc/BRIEF.md
# Eight-Bit GPIO Port with Peripheral Pin Override

This block controls one eight-bit general-purpose I/O port. Software reaches three registers over a simple synchronous bus with no wait states. The output data register holds the level driven on output pins. The direction register selects input or output for each pin. The pin register is read-only and returns the pin levels after they pass through a synchronizer. Only pins 7, 6, 1 and 0 exist. The other four positions are absent from every register and never drive a pad.

Two on-chip serial peripherals can claim pins 7 and 6. While the CAN controller is enabled, pin 7 becomes its transmit output and pin 6 becomes its receive input. While the two-wire (IIC) controller is enabled, pin 7 carries its clock line and pin 6 carries its data line. Both lines are driven open-drain: the pad is enabled only when the line is pulled low. If both peripherals are enabled at once, CAN owns the pins. An override never alters the stored direction bits, so the programmed setup returns as soon as the peripheral is disabled.

Top module: `gpio_override_port`

## Requirements
- R1: The pin register (address 1) is read-only. A bus write to it changes neither the direction register, the output data register, nor any pad output.
- R2: The pin register returns the synchronized pad level of every implemented pin, including pins configured as outputs. A shorted output therefore reads differently from the value it drives.
- R3: The direction register is at address 2. A bit of 1 makes the pin an output and a bit of 0 makes it an input. While reset is asserted the register reads 0 and every padOe bit is 0.
- R4: Bits 5 to 2 are absent from all three registers. They read as 0, writes to them have no effect, and padOe and padOut are always 0 on those bits.
- R5: While canEn is 1, pin 7 has padOe = 1 and padOut = canTx, and pin 6 has padOe = 0, whatever the direction bits hold.
- R6: While iicEn is 1 and canEn is 0, pins 7 (clock) and 6 (data) have padOut = 0 and padOe = the inverse of iicSclDrv and iicSdaDrv respectively. When both enables are 1, the CAN behaviour of R5 applies.
- R7: An override leaves the stored direction bits unchanged. Once the peripheral is disabled, padOe again equals the direction register on pins 7 and 6.
- R8: Pad sampling uses two register stages. The pin register reads 0 during reset. A pad level applied before a clock edge appears in the read data after the second rising edge.
- R9: The output data register is at address 0 and is read-write. On a pin whose direction bit is 1, a read returns the stored bit. On a pin whose direction bit is 0, a read returns the synchronized pad level. padOut equals the stored bit on output pins that no peripheral overrides.
- R10: A write takes effect at the clock edge on which busWe is 1. busRdata follows busAddr in the same cycle, and address 3 reads as 0.
- R11: The peripheral receive taps come straight from the pads: canRx = padIn[6], iicSclIn = padIn[7], iicSdaIn = padIn[6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 2 | Register address: 0 output data, 1 pin, 2 direction |
| busWe | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from busAddr |
| padIn | input | 8 | Pad input levels |
| padOe | output | 8 | Pad output enable |
| padOut | output | 8 | Pad output level |
| canEn | input | 1 | CAN controller owns pins 7 and 6 |
| canTx | input | 1 | CAN transmit level |
| canRx | output | 1 | CAN receive level from pin 6 |
| iicEn | input | 1 | Two-wire controller owns pins 7 and 6 |
| iicSclDrv | input | 1 | Clock line level requested (0 pulls low) |
| iicSdaDrv | input | 1 | Data line level requested (0 pulls low) |
| iicSclIn | output | 1 | Clock line level from pin 7 |
| iicSdaIn | output | 1 | Data line level from pin 6 |

## Verification
The bench programs a pin as an output and then drives the opposite level on its pad. A design that returned the register value instead of the pad would hide the short. It writes all ones to the read-only register and to the absent bit positions, then reads the other registers back. Stray decode would show up there as changed direction or data bits.

The bench counts edges after a pad change and after reset release. A one-stage or three-stage synchronizer reads the new level one cycle early or one cycle late. It enables CAN and IIC singly and together over a direction register that says the opposite. It then checks that the pads revert once the peripherals are disabled. A design that wrote the override into the direction register, gave IIC priority, or drove the two-wire lines push-pull would fail these checks.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_OUT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PIN = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DIR = 2'd2;

  typedef enum logic [1:0] {
    RD_OUT  = 2'd0,
    RD_PIN  = 2'd1,
    RD_DIR  = 2'd2,
    RD_NONE = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrOut;
    logic   wrDir;
    rdSel_e rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/gpio_ovr_ctrl.sv
module gpio_ovr_ctrl
  import gpio_ovr_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output ctrlStrobes_t      strobes
);
  always_comb begin
    strobes = '{wrOut: 1'b0, wrDir: 1'b0, rdSel: RD_NONE};
    unique case (busAddr)
      ADDR_OUT: begin
        strobes.wrOut = busWe;
        strobes.rdSel = RD_OUT;
      end
      ADDR_DIR: begin
        strobes.wrDir = busWe;
        strobes.rdSel = RD_DIR;
      end
      ADDR_PIN: strobes.rdSel = RD_PIN;
      default:  strobes.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_ovr_datapath.sv
module gpio_ovr_datapath
  import gpio_ovr_pkg::*;
#(
  parameter int           W           = 8,
  parameter logic [W-1:0] IMPL_MASK   = 8'hC3,
  parameter int           SYNC_STAGES = 2,
  parameter int           CAN_TX_BIT  = 7,
  parameter int           CAN_RX_BIT  = 6,
  parameter int           IIC_SCL_BIT = 7,
  parameter int           IIC_SDA_BIT = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic [W-1:0] busWdata,
  output logic [W-1:0] busRdata,
  input  logic [W-1:0] padIn,
  output logic [W-1:0] padOe,
  output logic [W-1:0] padOut,
  input  logic         canEn,
  input  logic         canTx,
  input  logic         iicEn,
  input  logic         iicSclDrv,
  input  logic         iicSdaDrv
);
  logic [W-1:0] dirReg;
  logic [W-1:0] outReg;
  logic [W-1:0] syncIn;
  logic [W-1:0] pinView;
  logic [W-1:0] dataView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= '0;
      outReg <= '0;
    end else begin
      if (strobes.wrDir) dirReg <= busWdata & IMPL_MASK;
      if (strobes.wrOut) outReg <= busWdata & IMPL_MASK;
    end
  end

  gpio_ovr_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (padIn),
    .dout (syncIn)
  );

  assign pinView  = syncIn & IMPL_MASK;
  assign dataView = ((dirReg & outReg) | (~dirReg & syncIn)) & IMPL_MASK;

  always_comb begin
    unique case (strobes.rdSel)
      RD_OUT:  busRdata = dataView;
      RD_PIN:  busRdata = pinView;
      RD_DIR:  busRdata = dirReg;
      default: busRdata = '0;
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    if (!IMPL_MASK[i]) begin : g_absent
      assign padOe[i]  = 1'b0;
      assign padOut[i] = 1'b0;
    end else begin : g_present
      logic pinOe;
      logic pinOut;
      always_comb begin
        pinOe  = dirReg[i];
        pinOut = outReg[i];
        if (canEn && i == CAN_TX_BIT) begin
          pinOe  = 1'b1;
          pinOut = canTx;
        end else if (canEn && i == CAN_RX_BIT) begin
          pinOe  = 1'b0;
          pinOut = 1'b0;
        end else if (iicEn && i == IIC_SCL_BIT) begin
          pinOe  = ~iicSclDrv;
          pinOut = 1'b0;
        end else if (iicEn && i == IIC_SDA_BIT) begin
          pinOe  = ~iicSdaDrv;
          pinOut = 1'b0;
        end
      end
      assign padOe[i]  = pinOe;
      assign padOut[i] = pinOut;
    end
  end
endmodule

// File: rtl/gpio_override_port.sv
module gpio_override_port
  import gpio_ovr_pkg::*;
#(
  parameter int          W           = 8,
  parameter logic [7:0]  IMPL_MASK   = 8'hC3,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [W-1:0]      busWdata,
  output logic [W-1:0]      busRdata,
  input  logic [W-1:0]      padIn,
  output logic [W-1:0]      padOe,
  output logic [W-1:0]      padOut,
  input  logic              canEn,
  input  logic              canTx,
  output logic              canRx,
  input  logic              iicEn,
  input  logic              iicSclDrv,
  input  logic              iicSdaDrv,
  output logic              iicSclIn,
  output logic              iicSdaIn
);
  localparam int CAN_TX_BIT  = 7;
  localparam int CAN_RX_BIT  = 6;
  localparam int IIC_SCL_BIT = 7;
  localparam int IIC_SDA_BIT = 6;

  ctrlStrobes_t strobes;

  gpio_ovr_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobes (strobes)
  );

  gpio_ovr_datapath #(
    .W           (W),
    .IMPL_MASK   (IMPL_MASK[W-1:0]),
    .SYNC_STAGES (SYNC_STAGES),
    .CAN_TX_BIT  (CAN_TX_BIT),
    .CAN_RX_BIT  (CAN_RX_BIT),
    .IIC_SCL_BIT (IIC_SCL_BIT),
    .IIC_SDA_BIT (IIC_SDA_BIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .padIn     (padIn),
    .padOe     (padOe),
    .padOut    (padOut),
    .canEn     (canEn),
    .canTx     (canTx),
    .iicEn     (iicEn),
    .iicSclDrv (iicSclDrv),
    .iicSdaDrv (iicSdaDrv)
  );

  assign canRx    = padIn[CAN_RX_BIT];
  assign iicSclIn = padIn[IIC_SCL_BIT];
  assign iicSdaIn = padIn[IIC_SDA_BIT];
endmodule

// File: rtl/gpio_override_port_chk.sv
module gpio_override_port_chk
  import gpio_ovr_pkg::*;
#(
  parameter int         W         = 8,
  parameter logic [7:0] IMPL_MASK = 8'hC3
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [W-1:0]      busRdata,
  input logic [W-1:0]      padIn,
  input logic [W-1:0]      padOe,
  input logic [W-1:0]      padOut,
  input logic              canEn,
  input logic              canTx,
  input logic              iicEn,
  input logic              iicSclDrv,
  input logic              iicSdaDrv
);
  localparam logic [W-1:0] MASK = IMPL_MASK[W-1:0];

  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assert_pin_ro_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_PIN && !canEn && !iicEn)
      |=> (canEn || iicEn || padOe == $past(padOe)));

  assert_dir_reset_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd0 && !canEn && !iicEn) |-> padOe == '0);

  assert_absent_bits_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe | padOut) & ~MASK) == '0);

  assert_can_override_R5: assert property (@(posedge clk) disable iff (!rstN)
    canEn |-> (padOe[7] && padOut[7] == canTx && !padOe[6]));

  assert_iic_open_drain_R6: assert property (@(posedge clk) disable iff (!rstN)
    (iicEn && !canEn) |-> (padOut[7:6] == 2'b00 &&
                           padOe[7] == !iicSclDrv && padOe[6] == !iicSdaDrv));

  assert_sync_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && busAddr == ADDR_PIN)
      |-> busRdata == ($past(padIn, 2) & MASK));
endmodule

bind gpio_override_port gpio_override_port_chk #(.W(W), .IMPL_MASK(IMPL_MASK)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWe     (busWe),
  .busRdata  (busRdata),
  .padIn     (padIn),
  .padOe     (padOe),
  .padOut    (padOut),
  .canEn     (canEn),
  .canTx     (canTx),
  .iicEn     (iicEn),
  .iicSclDrv (iicSclDrv),
  .iicSdaDrv (iicSdaDrv)
);

// File: tb/gpio_override_port_bench.sv
`timescale 1ns/1ps
module gpio_override_port_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic [7:0] padIn = 8'h00;
  logic [7:0] padOe;
  logic [7:0] padOut;
  logic       canEn = 1'b0;
  logic       canTx = 1'b0;
  logic       canRx;
  logic       iicEn = 1'b0;
  logic       iicSclDrv = 1'b1;
  logic       iicSdaDrv = 1'b1;
  logic       iicSclIn;
  logic       iicSdaIn;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  gpio_override_port u_gpio_override_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOe(padOe), .padOut(padOut), .canEn(canEn), .canTx(canTx),
    .canRx(canRx), .iicEn(iicEn), .iicSclDrv(iicSclDrv),
    .iicSdaDrv(iicSdaDrv), .iicSclIn(iicSclIn), .iicSdaIn(iicSdaIn)
  );

  // {writeAddr, writeData, padLevel, readAddr, expectedRead}
  localparam logic [27:0] VEC [10] = '{
    {2'd2, 8'hFF, 8'h00, 2'd2, 8'hC3},  // R3 R4: all outputs, absent bits drop
    {2'd0, 8'hA5, 8'h00, 2'd0, 8'h81},  // R9: output pins read stored bits
    {2'd2, 8'h03, 8'h40, 2'd2, 8'h03},  // R3
    {2'd0, 8'hFF, 8'h40, 2'd0, 8'h43},  // R9: mixed direction readback
    {2'd1, 8'hFF, 8'h82, 2'd1, 8'h82},  // R2: output pin 0 shorted low is visible
    {2'd1, 8'h00, 8'h82, 2'd2, 8'h03},  // R1: direction untouched
    {2'd1, 8'h00, 8'h82, 2'd0, 8'h83},  // R1: output data untouched
    {2'd3, 8'hFF, 8'h82, 2'd3, 8'h00},  // R10: unused address reads 0
    {2'd2, 8'h3C, 8'hFF, 2'd2, 8'h00},  // R4: absent bits ignore writes
    {2'd0, 8'h00, 8'hFF, 2'd0, 8'hC3}   // R9: input pins read pads
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic readAt(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd;
    padIn = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    readAt(2'd2, rd); check("R3 reset dir", rd, 8'h00);
    readAt(2'd1, rd); check("R8 reset pin reg", rd, 8'h00);
    check("R3 reset padOe", padOe, 8'h00);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    readAt(2'd1, rd); check("R8 one edge after reset", rd, 8'h00);
    @(posedge clk); @(negedge clk);
    readAt(2'd1, rd); check("R8 two edges after reset", rd, 8'hC3);

    for (int v = 0; v < 10; v++) begin
      @(negedge clk);
      padIn = VEC[v][17:10];
      busWrite(VEC[v][27:26], VEC[v][25:18]);
      repeat (2) @(posedge clk);
      @(negedge clk);
      readAt(VEC[v][9:8], rd);
      check($sformatf("R1 R2 R3 R4 R9 R10 vector %0d", v), rd, VEC[v][7:0]);
    end

    // R8 latency after a pad change
    padIn = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    padIn = 8'hC3;
    @(posedge clk); @(negedge clk);
    readAt(2'd1, rd); check("R8 one edge after change", rd, 8'h00);
    @(posedge clk); @(negedge clk);
    readAt(2'd1, rd); check("R8 two edges after change", rd, 8'hC3);

    // R9 / R4 pad drive
    busWrite(2'd2, 8'hFF);
    busWrite(2'd0, 8'hFE);
    check("R4 padOe absent bits", padOe, 8'hC3);
    check("R9 padOut follows data", padOut, 8'hC2);

    // R5 / R7 CAN override
    busWrite(2'd0, 8'h00);
    padIn = 8'h40;
    canEn = 1'b1; canTx = 1'b0;
    #1 check("R5 can oe", padOe, 8'h83);
    check("R5 can tx low", padOut, 8'h00);
    canTx = 1'b1;
    #1 check("R5 can tx high", padOut, 8'h80);
    check("R11 canRx", {7'd0, canRx}, 8'h01);
    readAt(2'd2, rd); check("R7 dir kept under can", rd, 8'hC3);
    canEn = 1'b0;
    #1 check("R7 dir restored after can", padOe, 8'hC3);

    // R6 / R7 IIC override
    busWrite(2'd2, 8'h00);
    iicEn = 1'b1; iicSclDrv = 1'b0; iicSdaDrv = 1'b1;
    #1 check("R6 scl low drive", padOe, 8'h80);
    check("R6 open drain out", padOut, 8'h00);
    iicSclDrv = 1'b1; iicSdaDrv = 1'b0;
    #1 check("R6 sda low drive", padOe, 8'h40);
    canEn = 1'b1; canTx = 1'b1;
    #1 check("R6 can priority oe", padOe, 8'h80);
    check("R6 can priority out", padOut, 8'h80);
    padIn = 8'h80;
    #1 check("R11 iic taps", {6'd0, iicSclIn, iicSdaIn}, 8'h02);
    canEn = 1'b0; iicEn = 1'b0;
    #1 check("R7 dir restored after iic", padOe, 8'h00);
    @(negedge clk);
    readAt(2'd2, rd); check("R7 dir kept under iic", rd, 8'h00);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule